// File: doc/BRIEF.md
# DPLL Operating-Mode Controller

This block decides which operating mode a telecom digital PLL is in. The rest of the PLL reports its state as a set of flags: whether the selected reference is qualified, whether the reference selection has just switched, whether the phase detector reports lock, and whether a fast loss of the reference was detected. From these flags, the controller steps the loop through six modes. Free-Run follows only the master clock. Pre-Locked and Lost-Phase briefly chase the reference. Locked tracks the reference. Temp-Holdover is a short coast after a disturbance. Holdover coasts on stored frequency.

Two configuration inputs shape the behaviour. The first chooses between automatic sequencing and external control. Under external control the mode follows a requested code, except that a disturbance while Locked still forces Temp-Holdover. The second sets the reaction to a fast loss while Locked. It either drops lock and goes to Lost-Phase, or keeps lock and coasts in Temp-Holdover. The outputs are the mode code, a loop-closed flag, a kept-lock flag and a periodic strobe that tells the holdover logic to capture the current frequency.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, mode is Free-Run and loopClosed, lockStatus and capStrobe are all 0.
- R2: The mode codes are Free-Run=0, Pre-Locked=1, Locked=2, Temp-Holdover=3, Lost-Phase=4 and Holdover=5; codes 6 and 7 never appear. loopClosed is 1 in every mode except Free-Run and Holdover.
- R3: Under automatic control, Free-Run and Holdover move to Pre-Locked when refQualified is 1. Otherwise they stay put, whatever lockDet, fastLoss and refSwitch show.
- R4: Under automatic control, Pre-Locked moves to Locked when lockDet is 1. If refQualified is 0, Pre-Locked and Lost-Phase go to Holdover instead, and this takes priority over lockDet.
- R5: Under automatic control, Locked with fastLoss=1 and unlockOnFast=1 moves to Lost-Phase and clears lockStatus.
- R6: In Locked with fastLoss=1 and unlockOnFast=0, the next mode is Temp-Holdover and lockStatus stays 1.
- R7: Under automatic control, Lost-Phase returns to Locked when lockDet is 1 and refQualified is 1.
- R8: Under automatic control, Locked with fastLoss=0 and refQualified=0 moves to Holdover. fastLoss is tested before refQualified.
- R9: Under external control (extCtrl=1), outside Temp-Holdover and without an R10 event, the next mode equals extMode when extMode is 0, 1, 2, 4 or 5. The codes 3, 6 and 7 keep the current mode.
- R10: Under external control, Locked moves to Temp-Holdover when refSwitch=1, refQualified=0 or fastLoss=1, whatever extMode requests.
- R11: Temp-Holdover lasts exactly TH_DWELL cycles under either kind of control, and extMode is ignored during it. On the last cycle it moves to Locked if refQualified=1, lockDet=1 and fastLoss=0, and to Holdover otherwise.
- R12: capStrobe is 1 only in Locked. It pulses in the CAP_PERIOD-th, 2*CAP_PERIOD-th and later cycles of an unbroken stay in Locked, counting the first cycle in Locked as cycle 1.
- R13: lockStatus is 1 exactly when the mode is Locked or Temp-Holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refQualified | input | 1 | The selected reference is qualified |
| refSwitch | input | 1 | The reference selection changed this cycle |
| lockDet | input | 1 | Lock report from the phase detector |
| fastLoss | input | 1 | Fast loss of the selected reference |
| unlockOnFast | input | 1 | 1: a fast loss in Locked drops lock; 0: lock is kept and the loop coasts |
| extCtrl | input | 1 | 1: external mode control; 0: automatic |
| extMode | input | 3 | Requested mode code under external control |
| mode | output | 3 | Current operating mode |
| loopClosed | output | 1 | The loop is closed |
| lockStatus | output | 1 | Lock is held (Locked or Temp-Holdover) |
| capStrobe | output | 1 | Frequency-capture strobe for the holdover logic |

## Verification
The hardest state to reach is the exit from Temp-Holdover. The decision happens only in the last cycle of the dwell window, and only after a fast loss or an external disturbance has been applied in Locked. The bench therefore drives the loop into Locked on purpose. It then holds lockDet and refQualified steady through the whole dwell, once to return to Locked and once to drop into Holdover. After that comes a long pseudo-random sweep with rare control toggles and a low fast-loss rate. A reference model in the bench, built from the requirements, tracks the expected mode and both counters on every cycle. This lets the sweep reach Temp-Holdover again and again with every mix of inputs at the final dwell cycle.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

  typedef enum logic [2:0] {
    MODE_FREE     = 3'd0,
    MODE_PRELOCK  = 3'd1,
    MODE_LOCKED   = 3'd2,
    MODE_TEMPHOLD = 3'd3,
    MODE_LOSTPH   = 3'd4,
    MODE_HOLDOVER = 3'd5
  } modeT;

  // Strobes from the sequencer to the timer/flag datapath
  typedef struct packed {
    logic capRun;    // stay in Locked: advance capture counter, else clear
    logic dwellRun;  // stay in Temp-Holdover: advance dwell counter, else clear
    logic lockSet;   // entering or staying in Locked
    logic lockClr;   // leaving the lock-held modes
  } ctrlStrobeT;

endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refQualified,
  input  logic       refSwitch,
  input  logic       lockDet,
  input  logic       fastLoss,
  input  logic       unlockOnFast,
  input  logic       extCtrl,
  input  logic [2:0] extMode,
  input  logic       dwellDone,
  output modeT       modeQ,
  output ctrlStrobeT strobes
);

  modeT modeNext;
  modeT reqMode;
  logic reqValid;
  logic extBreak;
  logic coastOk;

  // Decode the externally requested mode; Temp-Holdover and spare codes hold
  always_comb begin
    reqValid = 1'b1;
    reqMode  = MODE_FREE;
    case (extMode)
      3'd0:    reqMode = MODE_FREE;
      3'd1:    reqMode = MODE_PRELOCK;
      3'd2:    reqMode = MODE_LOCKED;
      3'd4:    reqMode = MODE_LOSTPH;
      3'd5:    reqMode = MODE_HOLDOVER;
      default: reqValid = 1'b0;
    endcase
  end

  assign extBreak = refSwitch | ~refQualified | fastLoss;
  assign coastOk  = refQualified & lockDet & ~fastLoss;

  always_comb begin
    modeNext = modeQ;
    if (modeQ == MODE_TEMPHOLD) begin
      if (dwellDone) begin
        modeNext = coastOk ? MODE_LOCKED : MODE_HOLDOVER;
      end
    end else if (extCtrl) begin
      if (modeQ == MODE_LOCKED && extBreak) begin
        modeNext = MODE_TEMPHOLD;
      end else if (reqValid) begin
        modeNext = reqMode;
      end
    end else begin
      case (modeQ)
        MODE_FREE: begin
          if (refQualified) modeNext = MODE_PRELOCK;
        end
        MODE_PRELOCK: begin
          if (!refQualified) modeNext = MODE_HOLDOVER;
          else if (lockDet)  modeNext = MODE_LOCKED;
        end
        MODE_LOCKED: begin
          if (fastLoss)           modeNext = unlockOnFast ? MODE_LOSTPH : MODE_TEMPHOLD;
          else if (!refQualified) modeNext = MODE_HOLDOVER;
        end
        MODE_LOSTPH: begin
          if (!refQualified) modeNext = MODE_HOLDOVER;
          else if (lockDet)  modeNext = MODE_LOCKED;
        end
        MODE_HOLDOVER: begin
          if (refQualified) modeNext = MODE_PRELOCK;
        end
        default: modeNext = MODE_FREE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_FREE;
    else       modeQ <= modeNext;
  end

  always_comb begin
    strobes.capRun   = (modeQ == MODE_LOCKED) && (modeNext == MODE_LOCKED);
    strobes.dwellRun = (modeQ == MODE_TEMPHOLD) && (modeNext == MODE_TEMPHOLD);
    strobes.lockSet  = (modeNext == MODE_LOCKED);
    strobes.lockClr  = (modeNext != MODE_LOCKED) && (modeNext != MODE_TEMPHOLD);
  end

endmodule

// File: rtl/dpll_mode_timers.sv
module dpll_mode_timers
  import dpll_mode_pkg::*;
#(
  parameter int unsigned CAP_PERIOD = 8,
  parameter int unsigned TH_DWELL   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  modeT       modeQ,
  input  ctrlStrobeT strobes,
  output logic       dwellDone,
  output logic       capStrobe,
  output logic       lockStatus,
  output logic       loopClosed
);

  localparam int unsigned CW = $clog2(CAP_PERIOD) + 1;
  localparam int unsigned DW = $clog2(TH_DWELL) + 1;
  localparam logic [CW-1:0] CAP_LAST   = CW'(CAP_PERIOD - 1);
  localparam logic [DW-1:0] DWELL_LAST = DW'(TH_DWELL - 1);

  logic [CW-1:0] capCnt;
  logic [DW-1:0] dwellCnt;
  logic          lockQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 capCnt <= '0;
    else if (!strobes.capRun)  capCnt <= '0;
    else if (capCnt == CAP_LAST) capCnt <= '0;
    else                       capCnt <= capCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  dwellCnt <= '0;
    else if (!strobes.dwellRun) dwellCnt <= '0;
    else                        dwellCnt <= dwellCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lockQ <= 1'b0;
    else if (strobes.lockSet) lockQ <= 1'b1;
    else if (strobes.lockClr) lockQ <= 1'b0;
  end

  assign dwellDone  = (dwellCnt == DWELL_LAST);
  assign capStrobe  = (modeQ == MODE_LOCKED) && (capCnt == CAP_LAST);
  assign lockStatus = lockQ;
  assign loopClosed = (modeQ != MODE_FREE) && (modeQ != MODE_HOLDOVER);

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int unsigned CAP_PERIOD = 8,
  parameter int unsigned TH_DWELL   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refQualified,
  input  logic       refSwitch,
  input  logic       lockDet,
  input  logic       fastLoss,
  input  logic       unlockOnFast,
  input  logic       extCtrl,
  input  logic [2:0] extMode,
  output logic [2:0] mode,
  output logic       loopClosed,
  output logic       lockStatus,
  output logic       capStrobe
);

  modeT       modeS;
  ctrlStrobeT strobeS;
  logic       dwellDoneS;

  dpll_mode_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .refQualified (refQualified),
    .refSwitch    (refSwitch),
    .lockDet      (lockDet),
    .fastLoss     (fastLoss),
    .unlockOnFast (unlockOnFast),
    .extCtrl      (extCtrl),
    .extMode      (extMode),
    .dwellDone    (dwellDoneS),
    .modeQ        (modeS),
    .strobes      (strobeS)
  );

  dpll_mode_timers #(
    .CAP_PERIOD (CAP_PERIOD),
    .TH_DWELL   (TH_DWELL)
  ) u_timers (
    .clk        (clk),
    .rstN       (rstN),
    .modeQ      (modeS),
    .strobes    (strobeS),
    .dwellDone  (dwellDoneS),
    .capStrobe  (capStrobe),
    .lockStatus (lockStatus),
    .loopClosed (loopClosed)
  );

  assign mode = modeS;

endmodule

// File: rtl/dpll_mode_chk.sv
module dpll_mode_chk #(
  parameter int unsigned CAP_PERIOD = 8,
  parameter int unsigned TH_DWELL   = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       refQualified,
  input logic       refSwitch,
  input logic       lockDet,
  input logic       fastLoss,
  input logic       unlockOnFast,
  input logic       extCtrl,
  input logic [2:0] extMode,
  input logic [2:0] mode,
  input logic       loopClosed,
  input logic       lockStatus,
  input logic       capStrobe
);

  a_r2_code_range: assert property (@(posedge clk) disable iff (!rstN)
    mode <= 3'd5);

  a_r3_free_holds: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd0 && !extCtrl && !refQualified) |=> (mode == 3'd0));

  a_r5_fast_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2 && !extCtrl && fastLoss && unlockOnFast) |=> (mode == 3'd4 && !lockStatus));

  a_r6_fast_coast: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2 && !extCtrl && fastLoss && !unlockOnFast) |=> (mode == 3'd3 && lockStatus));

  a_r10_ext_switch: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2 && extCtrl && refSwitch) |=> (mode == 3'd3));

  a_r11_coast_keeps_lock: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3) |-> lockStatus);

  a_r12_strobe_in_locked: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |-> (mode == 3'd2 && loopClosed));

  generate
    if (CAP_PERIOD > 1) begin : g_gap
      a_r12_strobe_gap: assert property (@(posedge clk) disable iff (!rstN)
        capStrobe |=> !capStrobe);
    end
  endgenerate

endmodule

bind dpll_mode_ctrl dpll_mode_chk #(
  .CAP_PERIOD (CAP_PERIOD),
  .TH_DWELL   (TH_DWELL)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .refQualified (refQualified),
  .refSwitch    (refSwitch),
  .lockDet      (lockDet),
  .fastLoss     (fastLoss),
  .unlockOnFast (unlockOnFast),
  .extCtrl      (extCtrl),
  .extMode      (extMode),
  .mode         (mode),
  .loopClosed   (loopClosed),
  .lockStatus   (lockStatus),
  .capStrobe    (capStrobe)
);

// File: tb/dpll_mode_ctrl_tb.sv
module dpll_mode_ctrl_tb;

  localparam int P = 3;  // capture period
  localparam int D = 4;  // temp-holdover dwell

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refQualified = 1'b0, refSwitch = 1'b0, lockDet = 1'b0, fastLoss = 1'b0;
  logic unlockOnFast = 1'b0, extCtrl = 1'b0;
  logic [2:0] extMode = 3'd0;
  logic [2:0] mode;
  logic loopClosed, lockStatus, capStrobe;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  // model state
  logic [2:0] mMode = 3'd0;
  int mCap = 0;
  int mDwell = 0;

  always #10 clk = ~clk;  // 50 MHz

  dpll_mode_ctrl #(.CAP_PERIOD(P), .TH_DWELL(D)) u_dut (
    .clk(clk), .rstN(rstN), .refQualified(refQualified), .refSwitch(refSwitch),
    .lockDet(lockDet), .fastLoss(fastLoss), .unlockOnFast(unlockOnFast),
    .extCtrl(extCtrl), .extMode(extMode), .mode(mode), .loopClosed(loopClosed),
    .lockStatus(lockStatus), .capStrobe(capStrobe));

  function automatic logic [2:0] refNext(input logic [2:0] cur, input int dwell);
    logic [2:0] n;
    n = cur;
    if (cur == 3'd3) begin                                     // R11
      if (dwell == D - 1) n = (refQualified && lockDet && !fastLoss) ? 3'd2 : 3'd5;
    end else if (extCtrl) begin
      if (cur == 3'd2 && (refSwitch || !refQualified || fastLoss)) n = 3'd3;  // R10
      else if (extMode != 3'd3 && extMode <= 3'd5) n = extMode;               // R9
    end else begin
      case (cur)
        3'd0, 3'd5: if (refQualified) n = 3'd1;                // R3
        3'd1, 3'd4: if (!refQualified) n = 3'd5; else if (lockDet) n = 3'd2;  // R4 R7
        3'd2: if (fastLoss) n = unlockOnFast ? 3'd4 : 3'd3;    // R5 R6
              else if (!refQualified) n = 3'd5;                // R8
        default: n = 3'd0;
      endcase
    end
    return n;
  endfunction

  task automatic cmp(input int act, input int exp, input string tag, input string what);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    cmp(mode, mMode, tag, "mode");
    cmp(loopClosed, (mMode != 3'd0 && mMode != 3'd5), "R2", "loopClosed");
    cmp(lockStatus, (mMode == 3'd2 || mMode == 3'd3), "R13", "lockStatus");
    cmp(capStrobe, (mMode == 3'd2 && mCap == P - 1), "R12", "capStrobe");
  endtask

  // Called at a negedge: drive inputs, advance model, wait one cycle, compare
  task automatic step(input logic rq, input logic rs, input logic ld, input logic fl,
                      input logic uf, input logic ec, input logic [2:0] em, input string tag);
    logic [2:0] n;
    refQualified = rq; refSwitch = rs; lockDet = ld; fastLoss = fl;
    unlockOnFast = uf; extCtrl = ec; extMode = em;
    n = refNext(mMode, mDwell);
    mCap   = (mMode == 3'd2 && n == 3'd2) ? ((mCap == P - 1) ? 0 : mCap + 1) : 0;
    mDwell = (mMode == 3'd3 && n == 3'd3) ? mDwell + 1 : 0;
    mMode  = n;
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R1");                 // during reset
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");                 // first cycle after reset
    // R3: Free-Run ignores everything but refQualified
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 1, 0, 3'd2, "R3");
    step(1, 0, 0, 0, 0, 0, 3'd0, "R3");          // -> Pre-Locked
    step(1, 0, 0, 0, 0, 0, 3'd0, "R4");          // stays
    step(1, 0, 1, 0, 0, 0, 3'd0, "R4");          // -> Locked
    for (int i = 0; i < 7; i++) step(1, 0, 1, 0, 0, 0, 3'd0, "R12");
    step(1, 0, 1, 1, 0, 0, 3'd0, "R6");          // -> Temp-Holdover, lock kept
    for (int i = 0; i < D; i++) step(1, 0, 1, 0, 0, 0, 3'd5, "R11");  // back to Locked
    cmp(mode, 2, "R11", "coast exit to Locked");
    step(1, 0, 1, 1, 1, 0, 3'd0, "R5");          // -> Lost-Phase, lock cleared
    step(1, 0, 1, 0, 1, 0, 3'd0, "R7");          // -> Locked
    step(0, 0, 1, 0, 0, 0, 3'd0, "R8");          // -> Holdover
    step(1, 0, 0, 0, 0, 0, 3'd0, "R3");          // -> Pre-Locked
    step(0, 0, 1, 0, 0, 0, 3'd0, "R4");          // no ref beats lock -> Holdover
    // external control
    step(0, 0, 0, 0, 0, 1, 3'd2, "R9");          // -> Locked on request
    step(1, 0, 1, 0, 0, 1, 3'd6, "R9");          // spare code holds
    step(1, 0, 1, 0, 0, 1, 3'd3, "R9");          // code 3 holds
    step(1, 1, 1, 0, 0, 1, 3'd2, "R10");         // switch -> Temp-Holdover
    for (int i = 0; i < D; i++) step(1, 0, 0, 0, 0, 1, 3'd0, "R11");  // -> Holdover
    cmp(mode, 5, "R11", "coast exit to Holdover");
    step(1, 0, 0, 0, 0, 1, 3'd4, "R9");          // -> Lost-Phase
    step(1, 0, 0, 0, 0, 1, 3'd0, "R9");          // -> Free-Run
    // pseudo-random sweep
    begin
      logic ec = 1'b0, uf = 1'b0;
      for (int i = 0; i < 20000; i++) begin
        if ($urandom_range(63) == 0) ec = ~ec;
        if ($urandom_range(15) == 0) uf = ~uf;
        step($urandom_range(7) != 0, $urandom_range(7) == 0, $urandom_range(1) == 1,
             $urandom_range(7) == 0, uf, ec, 3'($urandom_range(7)),
             ec ? "R9" : "R4");
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule